// File: doc/BRIEF.md
# Chained Big-Integer Double-Shift Unit

This block shifts an unsigned big integer by 0 to 63 bit positions. The integer is held as a small array of 64-bit limbs, and limb 0 is the least significant. The shift works in place, one limb per cycle.

Every step goes through the same primitive. The primitive rotates one limb left inside 64 bits. A mask then splits the rotated word into two parts. The kept part merges with a 64-bit shift-in word to form the result limb. The other part becomes a 64-bit shift-out word, and that word is the shift-in word of the next step. Because of this chaining, no 128-bit funnel shifter is needed and no copy of the vector is made. A shift by whole limbs is not handled here: it amounts to choosing different registers.

The array is filled and read through a load port and a read port. A sequencer runs the shift after a one-cycle start request. It reports busy while it works and pulses done for one cycle at the end. It also returns the 64 bits pushed out past the end of the vector on a spill output.

The sequencer has four named states:
- IDLE waits for start.
- PRIME only occurs for a downward shift. It reads limb 0 to seed the carry and the spill value.
- STEP writes one limb per cycle.
- DONE raises done for one cycle.

The transitions are:
- IDLE/DONE→STEP on start with an upward shift.
- IDLE/DONE→PRIME on start with a downward shift.
- PRIME→STEP always.
- STEP→STEP while limbs remain.
- STEP→DONE after the last limb.
- DONE→IDLE when no start is present.

Top module: `bshift_chain`

## Requirements
- R1: After reset, busy, done and spill are 0 and every limb of the array reads 0.
- R2: While the block is not busy, a cycle with load_en high writes load_data into limb load_idx. rd_data always shows, without a clock, the limb selected by rd_idx.
- R3: Only amount[5:0] gives the shift count s. Bits 63:6 of amount have no effect on the result.
- R4: With dir=0 (upward, toward more significant limbs), each limb i below the length becomes (L[i] << s) | (L[i-1] >> (64-s)). Limb 0 takes zeros from below. spill becomes L[len-1] >> (64-s).
- R5: With dir=1 (downward), each limb i below the length becomes (L[i] >> s) | (L[i+1] << (64-s)). The top limb takes zeros from above. spill becomes L[0] << (64-s).
- R6: With s=0, every limb is left unchanged in both directions and spill is 0.
- R7: The length is taken from len when start is accepted. A value of 0 acts as 1, and a value above the array depth acts as the depth. Limbs at or above the effective length are not altered.
- R8: busy is high from the cycle after an accepted start. done rises exactly len+1 cycles after that start for an upward shift, and len+2 cycles after it for a downward shift. done is high for one cycle, and busy is low in that cycle.
- R9: While busy, start and load_en are ignored. The running shift keeps its original count, direction and length, and the array is not written from the load port.
- R10: A start presented in the cycle in which done is high is accepted, and the next shift runs back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_en | input | 1 | Write load_data into the array (ignored while busy) |
| load_idx | input | 3 | Limb index for a load |
| load_data | input | 64 | Limb value for a load |
| rd_idx | input | 3 | Limb index for the read port |
| rd_data | output | 64 | Limb value at rd_idx (combinational) |
| start | input | 1 | One-cycle request to begin a shift (ignored while busy) |
| dir | input | 1 | 0 = shift toward more significant limbs, 1 = toward less significant |
| amount | input | 64 | Scalar shift operand; only bits 5:0 are used |
| len | input | 4 | Vector length in limbs, clamped to 1..8 |
| busy | output | 1 | Shift in progress |
| done | output | 1 | One-cycle completion pulse |
| spill | output | 64 | Bits pushed out past the end of the vector by the last shift |

## Verification
Two events can share one cycle: the completion cycle and the next start request. The bench waits until done is seen high. It then presents a new start with a different direction and count in that same cycle. The start is judged accepted if busy is high on the following cycle. The array must then hold both shifts composed in order, and the second run must report done after its own expected count. A second overlap is also provoked: start and load_en are raised during a running shift. The bench judges this case by the final array contents and by done arriving at the original run's count.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

    // Sequencer states
    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_PRIME = 2'd1,
        SQ_STEP  = 2'd2,
        SQ_DONE  = 2'd3
    } sq_state_e;

    // Shift direction as presented on the dir pin
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } shift_dir_e;

endpackage

// File: rtl/bshift_maskgen.sv
// Produces a mask whose upper keep_k bits are set and whose lower bits are clear.
module bshift_maskgen #(
    parameter int LIMB_W = 64
) (
    input  logic [$clog2(LIMB_W):0] keep_k,
    output logic [LIMB_W-1:0]       mask
);
    localparam int KW = $clog2(LIMB_W) + 1;

    logic [KW-1:0] keep_lim;
    assign keep_lim = keep_k;

    for (genvar gb = 0; gb < LIMB_W; gb++) begin : g_bit
        assign mask[gb] = ((int'(keep_lim) + gb) >= LIMB_W);
    end
endmodule

// File: rtl/bshift_merge.sv
// Rotate-and-merge primitive: rotate the limb left, keep the masked part,
// fill the rest from the shift-in word, and return the unmasked part.
module bshift_merge #(
    parameter int LIMB_W = 64
) (
    input  logic [LIMB_W-1:0]         a,
    input  logic [LIMB_W-1:0]         cin,
    input  logic [$clog2(LIMB_W)-1:0] rot_n,
    input  logic [$clog2(LIMB_W):0]   keep_k,
    output logic [LIMB_W-1:0]         res,
    output logic [LIMB_W-1:0]         cout
);
    logic [2*LIMB_W-1:0] dbl;
    logic [LIMB_W-1:0]   rotated;
    logic [LIMB_W-1:0]   mask;

    // rotate inside one limb: upper half of {a,a} shifted left
    assign dbl     = {a, a} << rot_n;
    assign rotated = dbl[2*LIMB_W-1:LIMB_W];

    bshift_maskgen #(.LIMB_W(LIMB_W)) u_mask (
        .keep_k (keep_k),
        .mask   (mask)
    );

    assign res  = (rotated & mask) | (cin & ~mask);
    assign cout = rotated & ~mask;
endmodule

// File: rtl/bshift_limb_store.sv
// Limb array: one write port, two combinational read ports.
module bshift_limb_store #(
    parameter int LIMB_W = 64,
    parameter int DEPTH  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_idx,
    input  logic [LIMB_W-1:0]        wr_data,
    input  logic [$clog2(DEPTH)-1:0] rd_a_idx,
    output logic [LIMB_W-1:0]        rd_a_data,
    input  logic [$clog2(DEPTH)-1:0] rd_b_idx,
    output logic [LIMB_W-1:0]        rd_b_data
);
    localparam int IDX_W = $clog2(DEPTH);

    logic [LIMB_W-1:0] limb_q [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_limb
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                limb_q[gi] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(gi))) begin
                limb_q[gi] <= wr_data;
            end
        end
    end

    assign rd_a_data = limb_q[rd_a_idx];
    assign rd_b_data = limb_q[rd_b_idx];
endmodule

// File: rtl/bshift_seq.sv
// Sequencer: walks the limbs from limb 0 upward and drives the merge primitive.
module bshift_seq
    import bshift_pkg::*;
#(
    parameter int LIMB_W = 64,
    parameter int DEPTH  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic                       dir_in,
    input  logic [$clog2(LIMB_W)-1:0]  amt_in,
    input  logic [$clog2(DEPTH+1)-1:0] len_in,
    input  logic [LIMB_W-1:0]          mrg_res,
    input  logic [LIMB_W-1:0]          mrg_cout,
    output logic                       busy,
    output logic                       done,
    output logic [$clog2(DEPTH)-1:0]   rd_idx,
    output logic                       rd_zero,
    output logic                       wr_en,
    output logic [$clog2(DEPTH)-1:0]   wr_idx,
    output logic [LIMB_W-1:0]          cin,
    output logic [$clog2(LIMB_W)-1:0]  rot_n,
    output logic [$clog2(LIMB_W):0]    keep_k,
    output logic [LIMB_W-1:0]          spill
);
    localparam int SH_W  = $clog2(LIMB_W);
    localparam int KW    = SH_W + 1;
    localparam int IDX_W = $clog2(DEPTH);
    localparam int LEN_W = $clog2(DEPTH + 1);

    sq_state_e         state_q, state_d;
    shift_dir_e        dir_q;
    logic [SH_W-1:0]   sh_q;
    logic [LEN_W-1:0]  len_q;
    logic [IDX_W-1:0]  k_q;
    logic [LIMB_W-1:0] carry_q;
    logic [LIMB_W-1:0] spill_q;

    logic [LEN_W-1:0]  len_eff;
    logic [LEN_W-1:0]  k_next;
    logic              last_step;
    logic              accept;

    // length clamp into 1..DEPTH
    always_comb begin
        if (len_in == '0) begin
            len_eff = LEN_W'(1);
        end else if (len_in > LEN_W'(DEPTH)) begin
            len_eff = LEN_W'(DEPTH);
        end else begin
            len_eff = len_in;
        end
    end

    assign k_next    = LEN_W'(k_q) + LEN_W'(1);
    assign last_step = (k_next == len_q);
    assign accept    = start && ((state_q == SQ_IDLE) || (state_q == SQ_DONE));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE, SQ_DONE: begin
                if (start) begin
                    state_d = (shift_dir_e'(dir_in) == DIR_DOWN) ? SQ_PRIME : SQ_STEP;
                end else begin
                    state_d = SQ_IDLE;
                end
            end
            SQ_PRIME: state_d = SQ_STEP;
            SQ_STEP:  state_d = last_step ? SQ_DONE : SQ_STEP;
            default:  state_d = SQ_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        busy    = 1'b0;
        done    = 1'b0;
        rd_idx  = k_q;
        rd_zero = 1'b0;
        wr_en   = 1'b0;
        wr_idx  = k_q;
        cin     = carry_q;
        unique case (state_q)
            SQ_IDLE: begin
            end
            SQ_PRIME: begin
                busy   = 1'b1;
                rd_idx = '0;
                cin    = '0;
            end
            SQ_STEP: begin
                busy  = 1'b1;
                wr_en = 1'b1;
                if (dir_q == DIR_DOWN) begin
                    rd_idx  = IDX_W'(k_next);
                    rd_zero = last_step;
                end
            end
            SQ_DONE: begin
                done = 1'b1;
            end
            default: begin
            end
        endcase

        if (dir_q == DIR_DOWN) begin
            rot_n  = SH_W'(0) - sh_q;
            keep_k = {1'b0, sh_q};
        end else begin
            rot_n  = sh_q;
            keep_k = KW'(LIMB_W) - {1'b0, sh_q};
        end
    end

    // operand latches, limb counter, carry and spill
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q   <= DIR_UP;
            sh_q    <= '0;
            len_q   <= LEN_W'(1);
            k_q     <= '0;
            carry_q <= '0;
            spill_q <= '0;
        end else if (accept) begin
            dir_q   <= shift_dir_e'(dir_in);
            sh_q    <= amt_in;
            len_q   <= len_eff;
            k_q     <= '0;
            carry_q <= '0;
            spill_q <= '0;
        end else if (state_q == SQ_PRIME) begin
            carry_q <= mrg_cout;
            spill_q <= mrg_res;
        end else if (state_q == SQ_STEP) begin
            carry_q <= mrg_cout;
            if (!last_step) begin
                k_q <= k_q + IDX_W'(1);
            end
            if (last_step && (dir_q == DIR_UP)) begin
                spill_q <= mrg_cout;
            end
        end
    end

    assign spill = spill_q;
endmodule

// File: rtl/bshift_chain.sv
// Top: limb array, sequencer and rotate-and-merge primitive.
module bshift_chain #(
    parameter int LIMB_W = 64,
    parameter int DEPTH  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load_en,
    input  logic [$clog2(DEPTH)-1:0]   load_idx,
    input  logic [LIMB_W-1:0]          load_data,
    input  logic [$clog2(DEPTH)-1:0]   rd_idx,
    output logic [LIMB_W-1:0]          rd_data,
    input  logic                       start,
    input  logic                       dir,
    input  logic [LIMB_W-1:0]          amount,
    input  logic [$clog2(DEPTH+1)-1:0] len,
    output logic                       busy,
    output logic                       done,
    output logic [LIMB_W-1:0]          spill
);
    localparam int SH_W  = $clog2(LIMB_W);
    localparam int IDX_W = $clog2(DEPTH);

    logic              seq_wr_en;
    logic [IDX_W-1:0]  seq_wr_idx;
    logic [IDX_W-1:0]  seq_rd_idx;
    logic              seq_rd_zero;
    logic [LIMB_W-1:0] seq_cin;
    logic [SH_W-1:0]   seq_rot;
    logic [SH_W:0]     seq_keep;
    logic [LIMB_W-1:0] mrg_res;
    logic [LIMB_W-1:0] mrg_cout;
    logic [LIMB_W-1:0] limb_raw;
    logic [LIMB_W-1:0] limb_in;

    logic              st_wr_en;
    logic [IDX_W-1:0]  st_wr_idx;
    logic [LIMB_W-1:0] st_wr_data;

    logic              unused_amt_hi;
    assign unused_amt_hi = ^amount[LIMB_W-1:SH_W];

    // sequencer owns the write port while it runs; loads only when not busy
    always_comb begin
        if (seq_wr_en) begin
            st_wr_en   = 1'b1;
            st_wr_idx  = seq_wr_idx;
            st_wr_data = mrg_res;
        end else begin
            st_wr_en   = load_en && !busy;
            st_wr_idx  = load_idx;
            st_wr_data = load_data;
        end
    end

    bshift_limb_store #(.LIMB_W(LIMB_W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (st_wr_en),
        .wr_idx    (st_wr_idx),
        .wr_data   (st_wr_data),
        .rd_a_idx  (seq_rd_idx),
        .rd_a_data (limb_raw),
        .rd_b_idx  (rd_idx),
        .rd_b_data (rd_data)
    );

    assign limb_in = seq_rd_zero ? '0 : limb_raw;

    bshift_seq #(.LIMB_W(LIMB_W), .DEPTH(DEPTH)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .dir_in   (dir),
        .amt_in   (amount[SH_W-1:0]),
        .len_in   (len),
        .mrg_res  (mrg_res),
        .mrg_cout (mrg_cout),
        .busy     (busy),
        .done     (done),
        .rd_idx   (seq_rd_idx),
        .rd_zero  (seq_rd_zero),
        .wr_en    (seq_wr_en),
        .wr_idx   (seq_wr_idx),
        .cin      (seq_cin),
        .rot_n    (seq_rot),
        .keep_k   (seq_keep),
        .spill    (spill)
    );

    bshift_merge #(.LIMB_W(LIMB_W)) u_merge (
        .a      (limb_in),
        .cin    (seq_cin),
        .rot_n  (seq_rot),
        .keep_k (seq_keep),
        .res    (mrg_res),
        .cout   (mrg_cout)
    );
endmodule

// File: rtl/bshift_chain_chk.sv
// Protocol checker attached to the top module.
module bshift_chain_chk #(
    parameter int DEPTH = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     start,
    input logic                     busy,
    input logic                     done,
    input logic                     seq_wr_en,
    input logic [$clog2(DEPTH)-1:0] seq_wr_idx
);
    localparam int IDX_W = $clog2(DEPTH);

    // R8: done lasts exactly one cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: busy and done never overlap
    a_r8_busy_done_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R8: an accepted start raises busy on the next cycle
    a_r8_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R9: a run ends only through the done cycle
    a_r9_busy_to_done: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));

    // R9: the sequencer writes the array only while busy
    a_r9_write_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        seq_wr_en |-> busy);

    // R7: the first write of a run goes to limb 0
    a_r7_first_limb: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_wr_en && !$past(seq_wr_en)) |-> (seq_wr_idx == '0));

    // R7: writes within a run step through consecutive limbs
    a_r7_consecutive: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_wr_en && $past(seq_wr_en)) |-> (seq_wr_idx == $past(seq_wr_idx) + IDX_W'(1)));
endmodule

bind bshift_chain bshift_chain_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .seq_wr_en  (seq_wr_en),
    .seq_wr_idx (seq_wr_idx)
);

// File: tb/bshift_chain_test.sv
module bshift_chain_test;
    localparam int W  = 64;
    localparam int D  = 8;
    localparam int IW = 3;
    localparam int LW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          load_en;
    logic [IW-1:0] load_idx;
    logic [W-1:0]  load_data;
    logic [IW-1:0] rd_idx;
    logic [W-1:0]  rd_data;
    logic          start;
    logic          dir;
    logic [W-1:0]  amount;
    logic [LW-1:0] len;
    logic          busy;
    logic          done;
    logic [W-1:0]  spill;

    int n_cmp = 0;
    int n_bad = 0;
    logic [W-1:0] mirror [D];
    logic [W-1:0] exp_spill;

    always #2 clk = ~clk;

    bshift_chain #(.LIMB_W(W), .DEPTH(D)) uut (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_idx(load_idx),
        .load_data(load_data), .rd_idx(rd_idx), .rd_data(rd_data),
        .start(start), .dir(dir), .amount(amount), .len(len),
        .busy(busy), .done(done), .spill(spill)
    );

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(4 * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run hung, actual=running expected=finished");
        summary();
        $finish;
    end

    task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] pat(int i, int seed);
        return (64'h9E37_79B9_7F4A_7C15 * 64'(i + 3)) ^ {32'(seed), 32'(seed * 7 + i)};
    endfunction

    function automatic int clamp_len(int l);
        if (l == 0) return 1;
        if (l > D) return D;
        return l;
    endfunction

    // bench model, built from R3..R7
    task automatic model(bit d, logic [W-1:0] amt, int l_in);
        logic [W-1:0] old [D];
        int s;
        int l;
        s = int'(amt[5:0]);
        l = clamp_len(l_in);
        for (int i = 0; i < D; i++) old[i] = mirror[i];
        for (int i = 0; i < l; i++) begin
            if (!d) begin
                mirror[i] = old[i] << s;
                if (i > 0 && s != 0) mirror[i] = mirror[i] | (old[i-1] >> (64 - s));
            end else begin
                mirror[i] = old[i] >> s;
                if (i < l - 1 && s != 0) mirror[i] = mirror[i] | (old[i+1] << (64 - s));
            end
        end
        if (s == 0) exp_spill = '0;
        else if (!d) exp_spill = old[l-1] >> (64 - s);
        else exp_spill = old[0] << (64 - s);
    endtask

    task automatic check_limbs(string tag);
        for (int i = 0; i < D; i++) begin
            rd_idx = IW'(i);
            #0.5;
            chk($sformatf("%s limb%0d", tag, i), rd_data, mirror[i]);
        end
    endtask

    task automatic load_all(int seed);
        for (int i = 0; i < D; i++) begin
            @(negedge clk);
            load_en   = 1'b1;
            load_idx  = IW'(i);
            load_data = pat(i, seed);
            mirror[i] = pat(i, seed);
        end
        @(negedge clk);
        load_en = 1'b0;
    endtask

    // issue a shift, optionally disturb it, check timing, array and spill
    task automatic run_shift(bit d, logic [W-1:0] amt, int l_in, bit intrude, string tag);
        int cnt;
        int exp_cnt;
        model(d, amt, l_in);
        exp_cnt = clamp_len(l_in) + (d ? 2 : 1);
        @(negedge clk);
        start = 1'b1; dir = d; amount = amt; len = LW'(l_in);
        @(negedge clk);
        start = 1'b0;
        chk({tag, " R8 busy after start"}, W'(busy), W'(1));
        cnt = 1;
        while (!done && cnt < 40) begin
            if (intrude && cnt == 2) begin
                // R9: these must all be ignored
                start = 1'b1; dir = ~d; amount = 64'd7; len = LW'(2);
                load_en = 1'b1; load_idx = '0; load_data = '1;
            end else begin
                start = 1'b0; load_en = 1'b0;
            end
            @(negedge clk);
            cnt++;
        end
        start = 1'b0; load_en = 1'b0;
        chk({tag, " R8 cycles to done"}, W'(cnt), W'(exp_cnt));
        chk({tag, " R8 busy low at done"}, W'(busy), W'(0));
        chk({tag, " spill"}, spill, exp_spill);
        @(negedge clk);
        chk({tag, " R8 done one cycle"}, W'(done), W'(0));
        check_limbs(tag);
    endtask

    task automatic t_reset();
        chk("R1 busy", W'(busy), W'(0));
        chk("R1 done", W'(done), W'(0));
        chk("R1 spill", spill, '0);
        for (int i = 0; i < D; i++) mirror[i] = '0;
        check_limbs("R1 array");
    endtask

    task automatic t_load_read();
        load_all(11);
        check_limbs("R2 load/read");
    endtask

    task automatic t_up();
        load_all(21);
        run_shift(1'b0, 64'd13, 8, 1'b0, "R4 up s13 len8");
        run_shift(1'b0, 64'd63, 3, 1'b0, "R4 up s63 len3");
    endtask

    task automatic t_down();
        load_all(31);
        run_shift(1'b1, 64'd37, 5, 1'b0, "R5 down s37 len5");
        run_shift(1'b1, 64'd1, 8, 1'b0, "R5 down s1 len8");
    endtask

    task automatic t_zero();
        load_all(41);
        run_shift(1'b0, 64'd0, 8, 1'b0, "R6 up s0");
        run_shift(1'b1, 64'd0, 6, 1'b0, "R6 down s0");
    endtask

    task automatic t_amount_hi();
        load_all(51);
        run_shift(1'b0, 64'hABCD_0000_0000_0049, 4, 1'b0, "R3 up hi bits");
        run_shift(1'b1, 64'hFFFF_FFFF_FFFF_FFC5, 7, 1'b0, "R3 down hi bits");
    endtask

    task automatic t_len_clamp();
        load_all(61);
        run_shift(1'b0, 64'd9, 0, 1'b0, "R7 len0 up");
        run_shift(1'b1, 64'd20, 15, 1'b0, "R7 len15 down");
        run_shift(1'b1, 64'd5, 1, 1'b0, "R7 len1 down");
    endtask

    task automatic t_busy_ignore();
        load_all(71);
        run_shift(1'b0, 64'd17, 6, 1'b1, "R9 up intruded");
        run_shift(1'b1, 64'd44, 6, 1'b1, "R9 down intruded");
    endtask

    task automatic t_back_to_back();
        int cnt;
        load_all(81);
        model(1'b0, 64'd3, 4);
        @(negedge clk);
        start = 1'b1; dir = 1'b0; amount = 64'd3; len = LW'(4);
        @(negedge clk);
        start = 1'b0;
        cnt = 1;
        while (!done && cnt < 40) begin
            @(negedge clk);
            cnt++;
        end
        // start in the done cycle
        start = 1'b1; dir = 1'b1; amount = 64'd50; len = LW'(5);
        model(1'b1, 64'd50, 5);
        @(negedge clk);
        start = 1'b0;
        chk("R10 busy after start at done", W'(busy), W'(1));
        cnt = 1;
        while (!done && cnt < 40) begin
            @(negedge clk);
            cnt++;
        end
        chk("R10 second run cycles", W'(cnt), W'(7));
        chk("R10 spill", spill, exp_spill);
        @(negedge clk);
        check_limbs("R10 composed");
    endtask

    initial begin
        rst_n = 1'b0; load_en = 1'b0; load_idx = '0; load_data = '0;
        rd_idx = '0; start = 1'b0; dir = 1'b0; amount = '0; len = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load_read();
        t_up();
        t_down();
        t_zero();
        t_amount_hi();
        t_len_clamp();
        t_busy_ignore();
        t_back_to_back();
        repeat (2) @(negedge clk);
        summary();
        $finish;
    end
endmodule